// File: doc/BRIEF.md
# Descriptor Ring Ownership Engine

This block is the device-side walker for a transmit ring and a receive ring of buffer descriptors that sit in shared memory. Each descriptor is a 16-byte slot with three live words: the buffer address (+0), a status and byte-count word called md1 (+4), and a count and error word called md2 (+8). Bit 31 of md1 carries ownership. The host sets it to hand a slot to the engine. The engine acts only on slots it owns. When it finishes a slot it writes the results back and clears the bit, which returns the slot to the host.

On the transmit side, a demand pulse or a poll tick starts a scan. The engine reads md1 of the current slot. If it owns the slot, it reads the buffer address, presents the buffer address and the positive byte count to the frame side, and waits for a completion with status. It then writes md2 and after that md1, pulses a transmit event, and moves on to the next slot. The scan stops at the first slot the engine does not own. On the receive side, a frame offered by the stimulus (a length and four error flags) goes into the current slot if the engine owns it. If the engine does not own the slot, the frame is held off until a poll tick. Ring length is 2^n, with n taken from the upper nibble of a configuration byte. A start pulse enables the engine and returns both ring indices to slot 0.

The controller is one state machine with these states: IDLE, RX_RD (read receive md1), RX_CHK (test ownership), RX_WR2, RX_WR1, TX_RD (read transmit md1), TX_CHK, TX_RDA (read buffer address), TX_GETA (latch address), TX_XFER (frame in flight), TX_WR2 and TX_WR1. The transitions are as follows. IDLE goes to RX_RD when a frame is offered and receive is not blocked. Otherwise IDLE goes to TX_RD when a scan is pending. RX_RD goes to RX_CHK. RX_CHK goes to RX_WR2 if the slot is owned, and otherwise to IDLE with receive blocked. RX_WR2 goes to RX_WR1, then IDLE. TX_RD goes to TX_CHK. TX_CHK goes to TX_RDA if the slot is owned, and otherwise to IDLE with the scan cleared. TX_RDA goes to TX_GETA, then TX_XFER. TX_XFER waits for completion and then goes to TX_WR2. TX_WR2 goes to TX_WR1, then IDLE. Start forces IDLE from any state.

Top module: `dre_ring_engine`

## Requirements
- R1: After reset and before the first start pulse, the engine makes no memory read or write, raises no tx_req, rx_ack, tint or rint, and ignores tx_demand, poll and rx_valid. All of these outputs are low out of reset.
- R2: Slot i of a ring lies at the ring base with its low 4 bits forced to zero, plus 16*i. The buffer address is at +0, md1 at +4 and md2 at +8. The slot index wraps to 0 after slot 2^n-1, where n = cfg[7:4], clamped to MAX_LOG2.
- R3: The engine writes nothing to a slot whose md1[31] reads 0. When a transmit scan meets such a slot, it stops until the next tx_demand or poll, and then re-reads that same slot. When a receive meets such a slot, the frame gets no rx_ack until a poll; tx_demand does not release it.
- R4: For an owned transmit slot, tx_buf_addr equals word +0 and tx_byte_cnt equals the two's-complement negation of md1[15:0]. Both are held with tx_req high until tx_done.
- R5: The transmit md2 write-back is tx_stat mapped as follows: bit 31 from [7] (buffer error), bit 30 from [6] (underflow), bit 28 from [5] (late collision), bit 27 from [4] (carrier loss), bit 26 from [3] (retry failure). All other bits are 0.
- R6: The transmit md1 write-back has bit 31 = 0. Bit 30 is the OR of tx_stat[7:3]. Bit 28 comes from [2] (several retries), bit 27 from [1] (one retry) and bit 26 from [0] (deferred). Bits 25:24 and 15:0 keep the values read. Bits 29 and 23:16 are 0.
- R7: For a receive, md2 = {20'b0, rx_msg_len}. In md1, bit 31 = 0, bit 30 is the OR of rx_err, and bits 29..26 take rx_err[3] (framing), [2] (overflow), [1] (CRC) and [0] (buffer). Bits 25:24 = 2'b11 and bits 23:16 = 0, while bits 15:0 keep the values read. rx_ack is high in the md1 write cycle.
- R8: Each slot is closed by an md2 write followed by an md1 write in the next cycle. tint (transmit) or rint (receive) is high for exactly that md1 write cycle.
- R9: A start pulse returns both ring indices to slot 0, so the next transmit and the next receive use slot 0 whatever slots were last used.
- R10: One tx_demand or poll pulse sends the engine through every consecutive owned transmit slot, with no further pulses, until it meets a slot it does not own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Enable engine and reload both ring indices |
| poll | input | 1 | Periodic poll tick: starts a transmit scan, releases a blocked receive |
| tx_demand | input | 1 | Transmit demand: starts a transmit scan |
| tx_ring_base | input | AW | Byte address of transmit ring (low 4 bits ignored) |
| rx_ring_base | input | AW | Byte address of receive ring (low 4 bits ignored) |
| tx_ring_cfg | input | 8 | Upper nibble: log2 of transmit ring length |
| rx_ring_cfg | input | 8 | Upper nibble: log2 of receive ring length |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| tx_req | output | 1 | Transmit frame in flight |
| tx_buf_addr | output | 32 | Buffer address of the frame |
| tx_byte_cnt | output | 16 | Positive byte count of the frame |
| tx_done | input | 1 | Frame finished; tx_stat valid |
| tx_stat | input | 8 | {buff, uflo, lcol, lcar, rtry, more, one, def} |
| rx_valid | input | 1 | Received frame offered; held until rx_ack |
| rx_msg_len | input | 12 | Received length including 4 CRC bytes |
| rx_err | input | 4 | {fram, oflo, crc, buff} |
| rx_ack | output | 1 | Frame stored in a slot |
| tint | output | 1 | Transmit completion event |
| rint | output | 1 | Receive completion event |

## Verification
Transmit frames are run with a clean status, with each error flag, and with retry and defer combinations. Stale bits are planted in the host-written md1 so that the field masking and summary bit show up. Several slots are made owned ahead of a single demand to separate a continuing scan from one that needs a pulse per slot. A scan that runs into an unowned slot separates stopping from skipping. A 4-slot transmit ring and a 2-slot receive ring make the wrap visible through the addresses written, and a misaligned receive base shows that the low bits are masked. A receive held on an unowned slot, first given a demand and then a poll, separates which pulse releases it. A start pulse sent after the indices have moved off slot 0 shows whether they reload.

// File: rtl/dre_pkg.sv
package dre_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RX_RD,
        S_RX_CHK,
        S_RX_WR2,
        S_RX_WR1,
        S_TX_RD,
        S_TX_CHK,
        S_TX_RDA,
        S_TX_GETA,
        S_TX_XFER,
        S_TX_WR2,
        S_TX_WR1
    } eng_state_t;

    typedef struct packed {
        logic buff;
        logic uflo;
        logic lcol;
        logic lcar;
        logic rtry;
        logic more;
        logic one;
        logic def;
    } tx_stat_t;

    typedef struct packed {
        logic fram;
        logic oflo;
        logic crc;
        logic buff;
    } rx_err_t;

    localparam int OWN_BIT   = 31;
    localparam int OFS_ADDR  = 0;
    localparam int OFS_MD1   = 4;
    localparam int OFS_MD2   = 8;
    localparam int SLOT_LOG2 = 4;

endpackage

// File: rtl/dre_ring_ptr.sv
module dre_ring_ptr #(
    parameter int MAX_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reload,
    input  logic                advance,
    input  logic [3:0]          cfg_log2,
    output logic [MAX_LOG2-1:0] idx
);
    localparam int IW = MAX_LOG2;

    logic [3:0]    eff_log2;
    logic [IW-1:0] wrap_mask;

    always_comb begin
        eff_log2 = (cfg_log2 > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : cfg_log2;
        for (int i = 0; i < IW; i++) begin
            wrap_mask[i] = (i < int'(eff_log2));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx + IW'(1)) & wrap_mask;
        end
    end

endmodule

// File: rtl/dre_stat_pack.sv
module dre_stat_pack
    import dre_pkg::*;
(
    input  logic [17:0] md1_keep,
    input  logic [7:0]  tx_stat_raw,
    input  logic [3:0]  rx_err_raw,
    input  logic [11:0] rx_len,
    output logic [31:0] tx_md1,
    output logic [31:0] tx_md2,
    output logic [31:0] rx_md1,
    output logic [31:0] rx_md2,
    output logic [15:0] byte_cnt
);
    tx_stat_t ts;
    rx_err_t  re;
    logic     tx_any_err;
    logic     rx_any_err;

    always_comb begin
        ts         = tx_stat_t'(tx_stat_raw);
        re         = rx_err_t'(rx_err_raw);
        tx_any_err = ts.buff | ts.uflo | ts.lcol | ts.lcar | ts.rtry;
        rx_any_err = re.fram | re.oflo | re.crc | re.buff;

        tx_md2 = {ts.buff, ts.uflo, 1'b0, ts.lcol, ts.lcar, ts.rtry, 26'b0};
        tx_md1 = {1'b0, tx_any_err, 1'b0, ts.more, ts.one, ts.def,
                  md1_keep[17:16], 8'h00, md1_keep[15:0]};

        rx_md2 = {20'b0, rx_len};
        rx_md1 = {1'b0, rx_any_err, re.fram, re.oflo, re.crc, re.buff,
                  2'b11, 8'h00, md1_keep[15:0]};

        byte_cnt = ~md1_keep[15:0] + 16'd1;
    end

endmodule

// File: rtl/dre_ring_engine.sv
module dre_ring_engine
    import dre_pkg::*;
#(
    parameter int AW       = 12,
    parameter int MAX_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          poll,
    input  logic          tx_demand,
    input  logic [AW-1:0] tx_ring_base,
    input  logic [AW-1:0] rx_ring_base,
    input  logic [7:0]    tx_ring_cfg,
    input  logic [7:0]    rx_ring_cfg,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_req,
    output logic [31:0]   tx_buf_addr,
    output logic [15:0]   tx_byte_cnt,
    input  logic          tx_done,
    input  logic [7:0]    tx_stat,
    input  logic          rx_valid,
    input  logic [11:0]   rx_msg_len,
    input  logic [3:0]    rx_err,
    output logic          rx_ack,
    output logic          tint,
    output logic          rint
);
    localparam int            IW        = MAX_LOG2;
    localparam logic [AW-1:0] SLOT_MASK = ~AW'((1 << SLOT_LOG2) - 1);

    eng_state_t state, nxt;

    logic          running;
    logic          tx_pend;
    logic          rx_block;
    logic [17:0]   md1_q;
    logic [31:0]   buf_q;
    logic [7:0]    stat_q;

    logic [IW-1:0] tx_idx, rx_idx;
    logic [AW-1:0] tx_slot, rx_slot;
    logic          rd_owned;

    logic [31:0]   tx_md1_w, tx_md2_w, rx_md1_w, rx_md2_w;
    logic [15:0]   cnt_w;

    logic          unused_bits;
    assign unused_bits = ^{mem_rdata[30:26], mem_rdata[23:16],
                           tx_ring_cfg[3:0], rx_ring_cfg[3:0]};

    assign rd_owned = mem_rdata[OWN_BIT];
    assign tx_slot  = (tx_ring_base & SLOT_MASK) + (AW'(tx_idx) << SLOT_LOG2);
    assign rx_slot  = (rx_ring_base & SLOT_MASK) + (AW'(rx_idx) << SLOT_LOG2);

    dre_ring_ptr #(.MAX_LOG2(MAX_LOG2)) u_tx_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (start),
        .advance  (state == S_TX_WR1),
        .cfg_log2 (tx_ring_cfg[7:4]),
        .idx      (tx_idx)
    );

    dre_ring_ptr #(.MAX_LOG2(MAX_LOG2)) u_rx_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (start),
        .advance  (state == S_RX_WR1),
        .cfg_log2 (rx_ring_cfg[7:4]),
        .idx      (rx_idx)
    );

    dre_stat_pack u_pack (
        .md1_keep    (md1_q),
        .tx_stat_raw (stat_q),
        .rx_err_raw  (rx_err),
        .rx_len      (rx_msg_len),
        .tx_md1      (tx_md1_w),
        .tx_md2      (tx_md2_w),
        .rx_md1      (rx_md1_w),
        .rx_md2      (rx_md2_w),
        .byte_cnt    (cnt_w)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (running && rx_valid && !rx_block) nxt = S_RX_RD;
                else if (running && tx_pend)          nxt = S_TX_RD;
            end
            S_RX_RD:   nxt = S_RX_CHK;
            S_RX_CHK:  nxt = rd_owned ? S_RX_WR2 : S_IDLE;
            S_RX_WR2:  nxt = S_RX_WR1;
            S_RX_WR1:  nxt = S_IDLE;
            S_TX_RD:   nxt = S_TX_CHK;
            S_TX_CHK:  nxt = rd_owned ? S_TX_RDA : S_IDLE;
            S_TX_RDA:  nxt = S_TX_GETA;
            S_TX_GETA: nxt = S_TX_XFER;
            S_TX_XFER: nxt = tx_done ? S_TX_WR2 : S_TX_XFER;
            S_TX_WR2:  nxt = S_TX_WR1;
            S_TX_WR1:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
        if (start) nxt = S_IDLE;
    end

    // Control flags and captured descriptor data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            tx_pend  <= 1'b0;
            rx_block <= 1'b0;
            md1_q    <= '0;
            buf_q    <= '0;
            stat_q   <= '0;
        end else begin
            if (start) running <= 1'b1;

            if (start)                            tx_pend <= 1'b0;
            else if (tx_demand || poll)           tx_pend <= 1'b1;
            else if (state == S_TX_CHK && !rd_owned) tx_pend <= 1'b0;

            if (start || poll)                    rx_block <= 1'b0;
            else if (state == S_RX_CHK && !rd_owned) rx_block <= 1'b1;

            if (state == S_RX_CHK || state == S_TX_CHK)
                md1_q <= {mem_rdata[25:24], mem_rdata[15:0]};
            if (state == S_TX_GETA)
                buf_q <= mem_rdata;
            if (state == S_TX_XFER && tx_done)
                stat_q <= tx_stat;
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_req    = 1'b0;
        rx_ack    = 1'b0;
        tint      = 1'b0;
        rint      = 1'b0;
        unique case (state)
            S_RX_RD: begin
                mem_rd   = 1'b1;
                mem_addr = rx_slot + AW'(OFS_MD1);
            end
            S_RX_WR2: begin
                mem_wr    = 1'b1;
                mem_addr  = rx_slot + AW'(OFS_MD2);
                mem_wdata = rx_md2_w;
            end
            S_RX_WR1: begin
                mem_wr    = 1'b1;
                mem_addr  = rx_slot + AW'(OFS_MD1);
                mem_wdata = rx_md1_w;
                rx_ack    = 1'b1;
                rint      = 1'b1;
            end
            S_TX_RD: begin
                mem_rd   = 1'b1;
                mem_addr = tx_slot + AW'(OFS_MD1);
            end
            S_TX_RDA: begin
                mem_rd   = 1'b1;
                mem_addr = tx_slot + AW'(OFS_ADDR);
            end
            S_TX_XFER: tx_req = 1'b1;
            S_TX_WR2: begin
                mem_wr    = 1'b1;
                mem_addr  = tx_slot + AW'(OFS_MD2);
                mem_wdata = tx_md2_w;
            end
            S_TX_WR1: begin
                mem_wr    = 1'b1;
                mem_addr  = tx_slot + AW'(OFS_MD1);
                mem_wdata = tx_md1_w;
                tint      = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_buf_addr = buf_q;
    assign tx_byte_cnt = cnt_w;

endmodule

// File: rtl/dre_ring_engine_chk.sv
module dre_ring_engine_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_req,
    input logic          tx_done,
    input logic [31:0]   tx_buf_addr,
    input logic [15:0]   tx_byte_cnt,
    input logic          rx_ack,
    input logic          tint,
    input logic          rint
);
    // R8
    evt_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tint || rint) |-> mem_wr);

    // R8
    md2_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tint || rint) |-> $past(mem_wr));

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tint || rint) |=> !(tint || rint));

    // R6
    own_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tint || rint) |-> !mem_wdata[31]);

    // R7
    rx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rint |-> (rx_ack && mem_wdata[25:24] == 2'b11));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done && !start) |=> tx_req);

    // R4
    req_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done && !start) |=> ($stable(tx_byte_cnt) && $stable(tx_buf_addr)));

    // R2
    word_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00 && mem_addr[3:2] != 2'b11));

    // R2
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind dre_ring_engine dre_ring_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .tx_req      (tx_req),
    .tx_done     (tx_done),
    .tx_buf_addr (tx_buf_addr),
    .tx_byte_cnt (tx_byte_cnt),
    .rx_ack      (rx_ack),
    .tint        (tint),
    .rint        (rint)
);

// File: tb/sim_dre_ring_engine.sv
`timescale 1ns/1ps
module sim_dre_ring_engine;
    localparam int AW = 12;
    localparam logic [11:0] TXB = 12'h000;
    localparam logic [11:0] RXB = 12'h800;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0, poll = 0, tx_demand = 0;
    logic [11:0] tx_ring_base = TXB;
    logic [11:0] rx_ring_base = 12'h805;
    logic [7:0]  tx_ring_cfg = 8'h20;
    logic [7:0]  rx_ring_cfg = 8'h10;
    logic mem_rd, mem_wr;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic tx_req;
    logic [31:0] tx_buf_addr;
    logic [15:0] tx_byte_cnt;
    logic tx_done = 0;
    logic [7:0] tx_stat = 0;
    logic rx_valid = 0;
    logic [11:0] rx_msg_len = 0;
    logic [3:0] rx_err = 0;
    logic rx_ack, tint, rint;

    always #5 clk = ~clk;

    dre_ring_engine #(.AW(AW), .MAX_LOG2(6)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .poll(poll), .tx_demand(tx_demand),
        .tx_ring_base(tx_ring_base), .rx_ring_base(rx_ring_base),
        .tx_ring_cfg(tx_ring_cfg), .rx_ring_cfg(rx_ring_cfg),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_byte_cnt(tx_byte_cnt),
        .tx_done(tx_done), .tx_stat(tx_stat),
        .rx_valid(rx_valid), .rx_msg_len(rx_msg_len), .rx_err(rx_err),
        .rx_ack(rx_ack), .tint(tint), .rint(rint)
    );

    int checks = 0, errors = 0;
    int wr_count = 0, rd_count = 0, ack_count = 0, req_count = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with host port
    logic [31:0] mem [0:1023] = '{default: 32'h0};
    logic        h_we = 0;
    logic [9:0]  h_addr = 0;
    logic [31:0] h_data = 0;
    always @(posedge clk) begin
        if (h_we)   mem[h_addr] <= h_data;
        if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    end

    task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); h_we = 1; h_addr = a[11:2]; h_data = d;
        @(negedge clk); h_we = 0;
    endtask

    // scoreboard queues
    logic [11:0] q_addr[$];
    logic [31:0] q_data[$];
    int          q_evt[$];
    string       q_tag[$];
    logic [31:0] r_buf[$];
    logic [15:0] r_cnt[$];
    logic [7:0]  r_stat[$];

    task automatic expect_wr(input logic [11:0] a, input logic [31:0] d, input int evt, input string tag);
        q_addr.push_back(a); q_data.push_back(d); q_evt.push_back(evt); q_tag.push_back(tag);
    endtask

    // write monitor
    always @(negedge clk) begin
        if (mem_rd) rd_count++;
        if (rx_ack) ack_count++;
        if (mem_wr) begin
            wr_count++;
            if (q_addr.size() == 0) begin
                check(0, "R3 unexpected write", {20'b0, mem_addr}, 32'h0);
            end else begin
                logic [11:0] ea; logic [31:0] ed; int ev; string tg;
                ea = q_addr.pop_front(); ed = q_data.pop_front();
                ev = q_evt.pop_front(); tg = q_tag.pop_front();
                check(mem_addr == ea, {tg, " R2 address"}, {20'b0, mem_addr}, {20'b0, ea});
                check(mem_wdata == ed, {tg, " data"}, mem_wdata, ed);
                check({rint, tint} == 2'(ev), "R8 event", {30'b0, rint, tint}, ev);
            end
        end
    end

    // frame-side responder
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (tx_req && !tx_done) begin
            if (wait_cnt == 0) req_count++;
            wait_cnt++;
            if (wait_cnt == 3) begin
                if (r_buf.size() == 0) begin
                    check(0, "R3 unexpected tx_req", tx_buf_addr, 32'h0);
                    tx_stat = 0;
                end else begin
                    logic [31:0] eb; logic [15:0] ec;
                    eb = r_buf.pop_front(); ec = r_cnt.pop_front();
                    check(tx_buf_addr == eb, "R4 buffer address", tx_buf_addr, eb);
                    check(tx_byte_cnt == ec, "R4 byte count", {16'b0, tx_byte_cnt}, {16'b0, ec});
                    tx_stat = r_stat.pop_front();
                end
                tx_done = 1;
                wait_cnt = 0;
            end
        end else begin
            tx_done = 0;
        end
    end

    task automatic pulse_start;  @(negedge clk); start = 1;  @(negedge clk); start = 0;  endtask
    task automatic pulse_demand; @(negedge clk); tx_demand = 1; @(negedge clk); tx_demand = 0; endtask
    task automatic pulse_poll;   @(negedge clk); poll = 1;   @(negedge clk); poll = 0;   endtask

    // transmit slot set-up plus expected results (R5, R6)
    task automatic tx_slot(input int idx, input logic [31:0] bufa, input int n, input logic [7:0] s);
        logic [11:0] a; logic [31:0] md1, e1, e2; logic [15:0] lo;
        a  = 12'(TXB + idx * 16);
        lo = 16'(-n);
        md1 = {1'b1, 1'b1, 4'hF, 2'b11, 8'h5A, lo};
        e2 = {s[7], s[6], 1'b0, s[5], s[4], s[3], 26'b0};
        e1 = {1'b0, |s[7:3], 1'b0, s[2], s[1], s[0], 2'b11, 8'h00, lo};
        host_wr(a, bufa);
        host_wr(a + 12'd8, 32'h0000_FFFF);
        host_wr(a + 12'd4, md1);
        expect_wr(a + 12'd8, e2, 0, "R5 md2");
        expect_wr(a + 12'd4, e1, 1, "R6 md1");
        r_buf.push_back(bufa); r_cnt.push_back(16'(n)); r_stat.push_back(s);
    endtask

    function automatic logic [31:0] rx_host_md1(input int idx);
        return {1'b1, 1'b1, 4'hF, 2'b00, 8'h33, 16'(-1536 + idx)};
    endfunction

    task automatic rx_prep(input int idx);
        logic [11:0] a;
        a = 12'(RXB + idx * 16);
        host_wr(a, 32'h2000_0000 + 32'(idx));
        host_wr(a + 12'd8, 32'h0);
        host_wr(a + 12'd4, rx_host_md1(idx));
    endtask

    task automatic rx_expect(input int idx, input logic [11:0] len, input logic [3:0] e);
        logic [11:0] a; logic [31:0] hm;
        a  = 12'(RXB + idx * 16);
        hm = rx_host_md1(idx);
        expect_wr(a + 12'd8, {20'b0, len}, 0, "R7 md2");
        expect_wr(a + 12'd4, {1'b0, |e, e, 2'b11, 8'h00, hm[15:0]}, 2, "R7 md1");
    endtask

    task automatic rx_send(input logic [11:0] len, input logic [3:0] e, input string tag);
        bit seen = 0;
        @(negedge clk); rx_valid = 1; rx_msg_len = len; rx_err = e;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (rx_ack) seen = 1;
        end
        rx_valid = 0;
        check(seen, tag, {31'b0, seen}, 32'h1);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 400 && (q_addr.size() != 0 || r_buf.size() != 0); i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(q_addr.size() == 0 && r_buf.size() == 0, tag, q_addr.size() + r_buf.size(), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet out of reset
        check({mem_rd, mem_wr, tx_req, rx_ack, tint, rint} == 6'b0, "R1 reset outputs",
              {26'b0, mem_rd, mem_wr, tx_req, rx_ack, tint, rint}, 32'h0);
        // R1: stimulus before start is ignored
        tx_slot(0, 32'h1000_0040, 60, 8'h00);
        rx_valid = 1; rx_msg_len = 12'd64;
        pulse_demand(); pulse_poll();
        repeat (20) @(negedge clk);
        rx_valid = 0;
        check(rd_count == 0 && wr_count == 0, "R1 no memory access before start", rd_count + wr_count, 0);
        check(req_count == 0 && ack_count == 0, "R1 no frame activity before start", req_count + ack_count, 0);

        pulse_start();
        // R4 R5 R6 R8: one clean frame in slot 0
        pulse_demand();
        drain("R10 first frame");

        // R10: three owned slots, one demand
        tx_slot(1, 32'h1000_0100, 1514, 8'h40);
        tx_slot(2, 32'h1000_0200, 64, 8'h03);
        tx_slot(3, 32'h1000_0300, 100, 8'h1C);
        pulse_demand();
        drain("R10 consecutive slots");

        // R3: index wrapped to slot 0 which is no longer owned
        begin
            int w0, r0;
            w0 = wr_count; r0 = rd_count;
            pulse_demand();
            repeat (30) @(negedge clk);
            check(wr_count == w0, "R3 no write to unowned tx slot", wr_count - w0, 0);
            check(rd_count > r0, "R3 unowned slot re-read on demand", rd_count - r0, 1);
        end
        // R2 wrap + R3 poll resumes: slot 0 again
        tx_slot(0, 32'h1000_0400, 42, 8'hA0);
        pulse_poll();
        drain("R2 wrap to slot 0");

        // R7 receive, masked base, two-slot ring
        rx_prep(0); rx_prep(1);
        rx_expect(0, 12'd64, 4'h0);
        rx_send(12'd64, 4'h0, "R7 clean receive ack");
        rx_expect(1, 12'd1518, 4'h2);
        rx_send(12'd1518, 4'h2, "R7 crc receive ack");
        drain("R7 receive writes");

        // R3 receive blocked on unowned slot 0
        begin
            int w0, a0;
            w0 = wr_count; a0 = ack_count;
            @(negedge clk); rx_valid = 1; rx_msg_len = 12'd100; rx_err = 4'h8;
            repeat (30) @(negedge clk);
            check(ack_count == a0 && wr_count == w0, "R3 rx held on unowned slot",
                  (ack_count - a0) + (wr_count - w0), 0);
            rx_prep(0);
            pulse_demand();
            repeat (20) @(negedge clk);
            check(ack_count == a0, "R3 demand does not release rx", ack_count - a0, 0);
            rx_expect(0, 12'd100, 4'h8);
            pulse_poll();
            for (int i = 0; i < 50 && ack_count == a0; i++) @(negedge clk);
            rx_valid = 0;
            check(ack_count == a0 + 1, "R3 poll releases rx", ack_count - a0, 1);
            drain("R3 released receive writes");
        end

        // R9: start reloads both indices (tx at 1, rx at 1 before this)
        pulse_start();
        tx_slot(0, 32'h1000_0500, 80, 8'h08);
        pulse_demand();
        drain("R9 tx index reload");
        rx_prep(0);
        rx_expect(0, 12'd72, 4'h5);
        rx_send(12'd72, 4'h5, "R9 rx after reload ack");
        drain("R9 rx index reload");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule